// File: doc/BRIEF.md
# Interrupt Redirection Entry Controller

This block watches a bank of external interrupt pins and turns pin activity into delivery requests. Each pin owns a programmable entry word that holds an 8-bit vector, an input polarity, an edge or level trigger choice, a mask, and a flag with no functional effect. Each pin's input is first corrected for polarity. Edge-mode pins then latch one pending event per inactive-to-active transition. Level-mode pins request delivery for as long as they stay active.

A fixed-priority selector picks the lowest-numbered eligible pin. It presents that pin's index and vector on a request port and holds them until the destination accepts. A level-mode pin sets a read-only remote-pending flag on acceptance. That flag blocks further delivery until an end-of-interrupt arrives that carries the pin's vector. A simple word-addressed port writes and reads the entry words and a boot configuration word whose bit 0 selects the delivery type.

Top module: `irq_route_ctrl`

## Requirements
- R1: Register map. Word offset 03h holds the boot word, and entry n sits at offset 10h + 2*n (pin 23 at 3Eh). Every other offset reads 0, and writes to it change nothing. Reads are combinational from `reg_addr_i`, and writes take effect at the clock edge where `reg_we_i` is high.
- R2: After reset every entry reads 00010000h (masked), the boot word reads 0, and no request is raised.
- R3: The entry fields are: bits 7:0 vector (RW), bit 13 polarity (RW, 1 = active low), bit 14 remote-pending (read-only), bit 15 trigger (RW, 1 = level), bit 16 mask (RW, 1 = masked), and bit 17 a stored flag (RW) with no effect on delivery. Bits 12:8 and 31:18 read 0 and ignore writes.
- R4: Boot word bit 0 is RW and drives `deliv_msg_o`. Bits 31:1 read 0.
- R5: Detection works on the pin XOR the polarity bit. An active-low pin held high does not request, and its falling edge does.
- R6: An edge-mode pin records one pending event per inactive-to-active transition of its corrected input, and acceptance clears that event. The request appears at the second rising clock edge after the pin change. A pin that stays active does not request again.
- R7: While an entry is masked, an edge-mode transition is discarded (clearing the mask afterwards delivers nothing), and a level-mode pin does not request.
- R8: A level-mode pin requests while its corrected input is active, it is unmasked, and its remote-pending bit is 0. Acceptance sets that bit. An end-of-interrupt whose vector equals the entry's vector clears it, and any other vector leaves it set.
- R9: Among eligible pins, the lowest-numbered pin is granted first.
- R10: `req_valid_o` stays high, with `req_pin_o` and `req_vec_o` unchanged, until `req_accept_i` is sampled high. In the cycle after acceptance, `req_valid_o` is low.
- R11: A new edge that reaches the pin in the same cycle as the acceptance of that pin's request stays pending and is delivered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | NUM_PINS | Raw interrupt pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word offset |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data for `reg_addr_i` |
| deliv_msg_o | output | 1 | Boot word delivery-type bit |
| req_valid_o | output | 1 | Delivery request pending |
| req_pin_o | output | PW | Index of the requesting pin |
| req_vec_o | output | 8 | Vector of the requesting pin |
| req_accept_i | input | 1 | Destination accepts the request |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vec_i | input | 8 | Vector carried by the end-of-interrupt |

## Verification
Acceptance of a pin's request and a fresh inactive-to-active edge on that same pin can land in one cycle. The edge must win, so that the pin is delivered again after the one-cycle gap. The bench provokes this by dropping the pin while its request is held, then raising the pin and asserting accept in the same cycle. It judges the result by the redelivery of that pin and vector, and by a cycle-by-cycle reference model. The model is also driven through end-of-interrupt strobes with matching and mismatching vectors while level pins are held active.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int VEC_W      = 8;
  localparam int BOOT_OFS   = 'h03;
  localparam int ENT_BASE   = 'h10;
  localparam int ENT_STRIDE = 2;
  localparam int B_FLUSH    = 17;
  localparam int B_MASK     = 16;
  localparam int B_TRIG     = 15;
  localparam int B_RIRR     = 14;
  localparam int B_POL      = 13;

  typedef struct packed {
    logic             flush;
    logic             mask;
    logic             trig;   // 1 = level
    logic             pol;    // 1 = active low
    logic [VEC_W-1:0] vec;
  } entry_t;

  localparam entry_t ENTRY_RST = '{flush: 1'b0, mask: 1'b1, trig: 1'b0, pol: 1'b0, vec: '0};
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs import irq_route_pkg::*; #(
  parameter int NUM_PINS = 24,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic [NUM_PINS-1:0]       rirr_i,
  output entry_t [NUM_PINS-1:0]     ent_o,
  output logic                      boot_o,
  output logic [DW-1:0]             rdata_o
);
  localparam logic [AW-1:0] BOOT_A = AW'(BOOT_OFS);

  logic [NUM_PINS-1:0] hit;
  logic                boot_q;
  logic                unused_wdata;

  assign unused_wdata = ^{wdata_i[DW-1:B_FLUSH+1], wdata_i[B_POL-1:VEC_W], wdata_i[B_RIRR]};

  function automatic logic [DW-1:0] pack_entry(entry_t e, logic rirr);
    logic [DW-1:0] w;
    w = '0;
    w[VEC_W-1:0] = e.vec;
    w[B_POL]     = e.pol;
    w[B_RIRR]    = rirr;
    w[B_TRIG]    = e.trig;
    w[B_MASK]    = e.mask;
    w[B_FLUSH]   = e.flush;
    return w;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      boot_q <= 1'b0;
    else if (we_i && addr_i == BOOT_A) boot_q <= wdata_i[0];
  end
  assign boot_o = boot_q;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_ent
    localparam logic [AW-1:0] OFS = AW'(ENT_BASE + ENT_STRIDE * n);
    entry_t q;
    assign hit[n] = (addr_i == OFS);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= ENTRY_RST;
      else if (we_i && hit[n])
        q <= '{flush: wdata_i[B_FLUSH], mask: wdata_i[B_MASK], trig: wdata_i[B_TRIG],
               pol: wdata_i[B_POL], vec: wdata_i[VEC_W-1:0]};
    end
    assign ent_o[n] = q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == BOOT_A) rdata_o[0] = boot_q;
    for (int n = 0; n < NUM_PINS; n++)
      if (hit[n]) rdata_o = pack_entry(ent_o[n], rirr_i[n]);
  end
endmodule

// File: rtl/irq_route_pin.sv
module irq_route_pin import irq_route_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  entry_t           ent_i,
  input  logic             acc_i,
  input  logic             eoi_valid_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  output logic             elig_o,
  output logic             rirr_o
);
  logic prev_q, pend_q, rirr_q;
  logic corr, rise, pend_d, rirr_d, eoi_hit;

  assign corr    = pin_i ^ ent_i.pol;
  assign rise    = corr & ~prev_q;
  assign eoi_hit = eoi_valid_i && (eoi_vec_i == ent_i.vec);

  // new edge beats acceptance in the same cycle
  always_comb begin
    pend_d = pend_q;
    if (ent_i.trig || ent_i.mask) pend_d = 1'b0;
    else if (rise)                pend_d = 1'b1;
    else if (acc_i)               pend_d = 1'b0;
  end

  always_comb begin
    rirr_d = rirr_q;
    if (acc_i && ent_i.trig) rirr_d = 1'b1;
    else if (eoi_hit)        rirr_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      prev_q <= corr;
      pend_q <= pend_d;
      rirr_q <= rirr_d;
    end
  end

  assign elig_o = ~ent_i.mask & (ent_i.trig ? (corr & ~rirr_q) : pend_q);
  assign rirr_o = rirr_q;
endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb import irq_route_pkg::*; #(
  parameter int NUM_PINS = 24,
  parameter int PW       = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_PINS-1:0]             elig_i,
  input  logic [NUM_PINS-1:0][VEC_W-1:0]  vec_i,
  input  logic                            accept_i,
  output logic                            valid_o,
  output logic [PW-1:0]                   pin_o,
  output logic [VEC_W-1:0]                vec_o,
  output logic [NUM_PINS-1:0]             acc_o
);
  logic             busy_q, found;
  logic [PW-1:0]    pin_q, pick;
  logic [VEC_W-1:0] vec_q;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        pick  = PW'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pin_q  <= '0;
      vec_q  <= '0;
    end else if (!busy_q) begin
      if (found) begin
        busy_q <= 1'b1;
        pin_q  <= pick;
        vec_q  <= vec_i[pick];
      end
    end else if (accept_i) begin
      busy_q <= 1'b0;
    end
  end

  always_comb
    for (int i = 0; i < NUM_PINS; i++)
      acc_o[i] = busy_q && accept_i && (pin_q == PW'(i));

  assign valid_o = busy_q;
  assign pin_o   = pin_q;
  assign vec_o   = vec_q;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl import irq_route_pkg::*; #(
  parameter int NUM_PINS = 24,
  parameter int AW       = 8,
  parameter int DW       = 32,
  localparam int PW      = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_pin_i,
  input  logic                reg_we_i,
  input  logic [AW-1:0]       reg_addr_i,
  input  logic [DW-1:0]       reg_wdata_i,
  output logic [DW-1:0]       reg_rdata_o,
  output logic                deliv_msg_o,
  output logic                req_valid_o,
  output logic [PW-1:0]       req_pin_o,
  output logic [VEC_W-1:0]    req_vec_o,
  input  logic                req_accept_i,
  input  logic                eoi_valid_i,
  input  logic [VEC_W-1:0]    eoi_vec_i
);
  entry_t [NUM_PINS-1:0]            ent;
  logic [NUM_PINS-1:0]              elig, rirr_v, acc, mask_v, trig_v;
  logic [NUM_PINS-1:0][VEC_W-1:0]   vec_all;

  irq_route_regs #(.NUM_PINS(NUM_PINS), .AW(AW), .DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rirr_i  (rirr_v),
    .ent_o   (ent),
    .boot_o  (deliv_msg_o),
    .rdata_o (reg_rdata_o)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    irq_route_pin u_pin (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_i       (irq_pin_i[n]),
      .ent_i       (ent[n]),
      .acc_i       (acc[n]),
      .eoi_valid_i (eoi_valid_i),
      .eoi_vec_i   (eoi_vec_i),
      .elig_o      (elig[n]),
      .rirr_o      (rirr_v[n])
    );
    assign vec_all[n] = ent[n].vec;
    assign mask_v[n]  = ent[n].mask;
    assign trig_v[n]  = ent[n].trig;
  end

  irq_route_arb #(.NUM_PINS(NUM_PINS), .PW(PW)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .elig_i   (elig),
    .vec_i    (vec_all),
    .accept_i (req_accept_i),
    .valid_o  (req_valid_o),
    .pin_o    (req_pin_o),
    .vec_o    (req_vec_o),
    .acc_o    (acc)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk import irq_route_pkg::*; #(
  parameter int NUM_PINS = 24,
  parameter int PW       = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [PW-1:0]       req_pin_i,
  input  logic [VEC_W-1:0]    req_vec_i,
  input  logic                req_accept_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] trig_i,
  input  logic [NUM_PINS-1:0] rirr_i
);
  logic [NUM_PINS-1:0] mask_q;
  logic                ack_lvl_q;
  logic [PW-1:0]       ack_pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '1;
      ack_lvl_q <= 1'b0;
      ack_pin_q <= '0;
    end else begin
      mask_q    <= mask_i;
      ack_lvl_q <= req_valid_i && req_accept_i && trig_i[req_pin_i];
      ack_pin_q <= req_pin_i;
    end
  end

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_accept_i |=> req_valid_i && $stable(req_pin_i) && $stable(req_vec_i));

  p_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_accept_i |=> !req_valid_i);

  p_pin_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> int'(req_pin_i) < NUM_PINS);

  p_rirr_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_lvl_q |-> rirr_i[ack_pin_q]);

  p_unmasked_pick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_i) |-> !mask_q[req_pin_i]);
endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_PINS(NUM_PINS), .PW(PW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_o),
  .req_pin_i    (req_pin_o),
  .req_vec_i    (req_vec_o),
  .req_accept_i (req_accept_i),
  .mask_i       (mask_v),
  .trig_i       (trig_v),
  .rirr_i       (rirr_v)
);

// File: tb/irq_route_ctrl_test.sv
`timescale 1ns/1ps
module irq_route_ctrl_test;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0] pins = '0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic         accept = 1'b0;
  logic         eoi_v = 1'b0;
  logic [7:0]   eoi_vec = '0;

  logic [31:0] rdata;
  logic        dt, valid;
  logic [4:0]  rpin;
  logic [7:0]  rvec;

  irq_route_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pins), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .deliv_msg_o(dt), .req_valid_o(valid),
    .req_pin_o(rpin), .req_vec_o(rvec), .req_accept_i(accept), .eoi_valid_i(eoi_v),
    .eoi_vec_i(eoi_vec)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [7:0] m_vec [N];
  bit m_pol [N], m_tm [N], m_mask [N], m_fl [N], m_rirr [N], m_pend [N], m_prev [N];
  bit m_busy, m_boot;
  int m_pin;
  logic [7:0] m_vecq;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] w;
    int n;
    w = '0;
    if (a == 8'h03) w[0] = m_boot;
    else if (a >= 8'h10 && a <= 8'h3E && a[0] == 1'b0) begin
      n = (int'(a) - 16) / 2;
      w = {14'd0, m_fl[n], m_mask[n], m_tm[n], m_rirr[n], m_pol[n], 5'd0, m_vec[n]};
    end
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit el [N];
    bit acc, corr, rise, hit;
    int n;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_vec[i] = '0; m_pol[i] = 0; m_tm[i] = 0; m_mask[i] = 1; m_fl[i] = 0;
        m_rirr[i] = 0; m_pend[i] = 0; m_prev[i] = 0;
      end
      m_busy = 0; m_boot = 0; m_pin = 0; m_vecq = '0;
    end else begin
      acc = m_busy && accept;
      for (int i = 0; i < N; i++) begin
        corr  = pins[i] ^ m_pol[i];
        rise  = corr && !m_prev[i];
        el[i] = !m_mask[i] && (m_tm[i] ? (corr && !m_rirr[i]) : m_pend[i]);
        hit   = acc && (m_pin == i);
        if (m_tm[i] || m_mask[i]) m_pend[i] = 0;
        else if (rise)            m_pend[i] = 1;
        else if (hit)             m_pend[i] = 0;
        if (hit && m_tm[i])                         m_rirr[i] = 1;
        else if (eoi_v && eoi_vec == m_vec[i])      m_rirr[i] = 0;
        m_prev[i] = corr;
      end
      if (!m_busy) begin
        for (int i = N - 1; i >= 0; i--)
          if (el[i]) begin m_busy = 1; m_pin = i; end
        if (m_busy) m_vecq = m_vec[m_pin];
      end else if (acc) m_busy = 0;
      if (we) begin
        if (addr == 8'h03) m_boot = wdata[0];
        else if (addr >= 8'h10 && addr <= 8'h3E && addr[0] == 1'b0) begin
          n = (int'(addr) - 16) / 2;
          m_vec[n] = wdata[7:0]; m_pol[n] = wdata[13]; m_tm[n] = wdata[15];
          m_mask[n] = wdata[16]; m_fl[n] = wdata[17];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(valid == m_busy, "R10 model valid", 32'(valid), 32'(m_busy));
      if (m_busy) chk(rpin == 5'(m_pin) && rvec == m_vecq, "R9 model pin/vec",
                      {19'd0, rpin, rvec}, {19'd0, 5'(m_pin), m_vecq});
      chk(rdata == m_read(addr), "R1 model rdata", rdata, m_read(addr));
      chk(dt == m_boot, "R4 model boot", 32'(dt), 32'(m_boot));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d; tick(); we = 1'b0;
  endtask
  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    addr = a; @(negedge clk); chk(rdata == e, tag, rdata, e); tick();
  endtask
  task automatic idle_chk(input int n, input string tag);
    repeat (n) begin @(negedge clk); chk(!valid, tag, 32'(valid), 0); tick(); end
  endtask
  task automatic wait_req(input int p, input logic [7:0] v, input string tag);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (valid) break;
      tick();
    end
    chk(valid && rpin == 5'(p) && rvec == v, tag, {18'd0, valid, rpin, rvec}, {18'd0, 1'b1, 5'(p), v});
  endtask
  task automatic take();
    accept = 1'b1; tick(); accept = 1'b0;
  endtask
  task automatic eoi(input logic [7:0] v);
    eoi_v = 1'b1; eoi_vec = v; tick(); eoi_v = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2 reset state
    rd_chk(8'h10, 32'h0001_0000, "R2 entry0 reset");
    rd_chk(8'h3E, 32'h0001_0000, "R2 entry23 reset");
    rd_chk(8'h03, 32'h0, "R2 boot reset");
    idle_chk(1, "R2 no request");
    // R3 field layout
    wr(8'h1A, 32'hFFFF_FFFF);
    rd_chk(8'h1A, 32'h0003_A0FF, "R3 fields");
    wr(8'h1A, 32'h0001_0000);
    // R4 boot word
    wr(8'h03, 32'hFFFF_FFFF);
    rd_chk(8'h03, 32'h1, "R4 boot");
    chk(dt == 1'b1, "R4 deliv_msg_o", 32'(dt), 1);
    // R1 holes
    wr(8'h11, 32'hFFFF_FFFF);
    rd_chk(8'h11, 32'h0, "R1 odd offset");
    rd_chk(8'h10, 32'h0001_0000, "R1 neighbour untouched");
    rd_chk(8'h40, 32'h0, "R1 beyond map");
    rd_chk(8'h0F, 32'h0, "R1 below map");
    // R6 edge
    wr(8'h14, 32'h42);
    pins[2] = 1'b1; tick();
    wait_req(2, 8'h42, "R6 edge request");
    take();
    idle_chk(4, "R6 one per edge");
    // R11 edge in accept cycle
    pins[2] = 1'b0; tick(); pins[2] = 1'b1; tick();
    wait_req(2, 8'h42, "R6 second edge");
    pins[2] = 1'b0; tick();
    pins[2] = 1'b1; accept = 1'b1; tick(); accept = 1'b0;
    @(negedge clk); chk(!valid, "R10 gap after accept", 32'(valid), 0); tick();
    wait_req(2, 8'h42, "R11 redelivered");
    take();
    idle_chk(3, "R11 single redelivery");
    // R5 polarity
    pins[3] = 1'b1; tick();
    wr(8'h16, 32'h0000_2033);
    idle_chk(3, "R5 active-low idle high");
    pins[3] = 1'b0; tick();
    wait_req(3, 8'h33, "R5 falling edge");
    take();
    // R7 mask
    wr(8'h18, 32'h0001_0044);
    pins[4] = 1'b1; tick(); pins[4] = 1'b0; tick();
    wr(8'h18, 32'h0000_0044);
    idle_chk(4, "R7 masked edge dropped");
    wr(8'h1C, 32'h0001_8066);
    pins[6] = 1'b1; tick();
    idle_chk(4, "R7 masked level");
    // R8 level and remote pending
    wr(8'h1C, 32'h0000_8066);
    wait_req(6, 8'h66, "R8 level request");
    take();
    rd_chk(8'h1C, 32'h0000_C066, "R8 remote flag set");
    idle_chk(3, "R8 blocked");
    eoi(8'h65);
    idle_chk(2, "R8 wrong vector");
    rd_chk(8'h1C, 32'h0000_C066, "R8 flag kept");
    eoi(8'h66);
    wait_req(6, 8'h66, "R8 redeliver after eoi");
    take();
    pins[6] = 1'b0;
    eoi(8'h66);
    rd_chk(8'h1C, 32'h0000_8066, "R8 flag cleared");
    idle_chk(3, "R8 inactive level");
    // R9 priority, R10 hold, R3 flush flag inert
    wr(8'h20, 32'h0002_0080);
    wr(8'h22, 32'h0000_0090);
    wr(8'h24, 32'h0000_00A0);
    pins[10:8] = 3'b111; tick();
    wait_req(8, 8'h80, "R9 lowest first");
    repeat (3) begin
      tick();
      @(negedge clk);
      chk(valid && rpin == 5'd8 && rvec == 8'h80, "R10 hold", {18'd0, valid, rpin, rvec}, {18'd0, 1'b1, 5'd8, 8'h80});
    end
    take();
    wait_req(9, 8'h90, "R9 second");
    take();
    wait_req(10, 8'hA0, "R9 third");
    take();
    idle_chk(3, "R9 drained");
    rd_chk(8'h20, 32'h0002_0080, "R3 flush flag stored");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R10 watchdog act=hung exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule